// File: doc/BRIEF.md
# Word-Strobed Serial Transmitter with Internal Loopback

This block turns a stream of 10-bit line code groups into a single serial bit stream. It runs on one fast bit clock; a one-cycle word strobe, asserted once every ten bit clocks, stands in for the word-rate reference edge. On each strobe the block samples the parallel word into a holding register. On the same strobe the word held from the previous strobe moves into a shifter and is sent out, least significant bit first, one bit per bit clock. With strobes spaced exactly ten cycles apart, consecutive words leave back to back with no idle bits between them. The first bit of a word reaches the line eleven bit clocks after the edge that captured it.

A loopback control steers the serial stream to a separate output that feeds the local receiver. While loopback is on, the true line output is parked high and its complement low. While loopback is off, the loopback output is quiet and the line pair carries the data. When no word is being sent, including the time after reset, the data line idles low.

Top module: `ser10_tx`

## Requirements
- R1: While rst_ni is low, and after reset until the first transmitted word begins, line_p_o is 0, line_n_o is 1 and lpbk_o is 0.
- R2: word_i is sampled only in a cycle where word_stb_i is high; changes to word_i in any other cycle have no effect on the serial outputs.
- R3: A word sampled at strobe edge k starts transmission at the next strobe edge k'. Its bit 0 is visible on the serial output during the cycle after edge k'+1, which is 11 cycles after capture when strobes are 10 cycles apart. The first strobe after reset starts no transmission, because no word is held yet.
- R4: Bits leave in order: bit i of the word is on the serial output exactly i cycles after bit 0, for i = 0 to 9. Bit 0 goes first and bit 9 last.
- R5: With strobes exactly 10 cycles apart, the last bit of one word is followed directly by bit 0 of the next word, with no idle cycle between them.
- R6: If no strobe arrives by the cycle after a word's bit 9 has been sent, the data line returns to 0 and stays there until the next transmission begins.
- R7: When lpbk_i is high at an edge, then after that edge line_p_o is 1, line_n_o is 0, and lpbk_o carries the serial data bit that the line would otherwise carry.
- R8: When lpbk_i is low at an edge, then after that edge lpbk_o is 0 and line_p_o carries the serial data bit.
- R9: line_n_o is always the complement of line_p_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_stb_i | input | 1 | One-cycle word strobe, nominally every 10 bit clocks |
| word_i | input | 10 | Parallel code group, bit 0 sent first |
| lpbk_i | input | 1 | Loopback enable |
| line_p_o | output | 1 | Serial line output, true polarity |
| line_n_o | output | 1 | Serial line output, complement |
| lpbk_o | output | 1 | Serial stream steered to the local receiver in loopback |

## Verification
The bench sends words whose bit patterns expose the order in which bits leave: single set bits at either end, alternating patterns, all ones and all zeros. A shifter that runs in the wrong direction, or that sends bit 9 first, would produce mirrored bits. The bench also checks the word boundary cycle. A design that reloads one cycle late inserts an idle bit. A design that does not stop after bit 9 repeats stale bits or keeps driving a 1 after an irregular gap. A design that starts on the first strobe after reset sends garbage or zeros one word early. The bench also changes the loopback setting in the middle of a word and applies reset in the middle of a stream. This catches an output stage that leaks data onto the line while loopback is on, or that keeps a held word across reset.

// File: rtl/ser10_pkg.sv
package ser10_pkg;

  // serial output triple produced by the output stage
  typedef struct packed {
    logic p;
    logic n;
    logic lb;
  } ser_out_t;

  localparam ser_out_t SER_OUT_RST = '{p: 1'b0, n: 1'b1, lb: 1'b0};

endpackage

// File: rtl/ser10_in_reg.sv
module ser10_in_reg #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stb_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o,
  output logic         vld_o
);

  logic [W-1:0] word_q;
  logic         vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else if (stb_i) begin
      word_q <= word_i;
      vld_q  <= 1'b1;
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;

endmodule

// File: rtl/ser10_shifter.sv
module ser10_shifter #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stb_i,
  input  logic [W-1:0] word_i,
  input  logic         vld_i,
  output logic         bit_o,
  output logic         act_o
);

  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (stb_i) begin
      // held word from previous strobe starts now
      sh_q  <= word_i;
      cnt_q <= '0;
      act_q <= vld_i;
    end else if (act_q) begin
      if (cnt_q == LAST) begin
        act_q <= 1'b0;
      end else begin
        sh_q  <= sh_q >> 1;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign bit_o = sh_q[0];
  assign act_o = act_q;

endmodule

// File: rtl/ser10_out_stage.sv
module ser10_out_stage
  import ser10_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic act_i,
  input  logic lpbk_i,
  output logic line_p_o,
  output logic line_n_o,
  output logic lpbk_o
);

  ser_out_t out_q, out_d;
  logic     data_bit;

  always_comb begin
    data_bit = act_i & bit_i;
    out_d.p  = lpbk_i | data_bit;
    out_d.n  = ~(lpbk_i | data_bit);
    out_d.lb = lpbk_i & data_bit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= SER_OUT_RST;
    else         out_q <= out_d;
  end

  assign line_p_o = out_q.p;
  assign line_n_o = out_q.n;
  assign lpbk_o   = out_q.lb;

endmodule

// File: rtl/ser10_tx.sv
module ser10_tx #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_stb_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              lpbk_i,
  output logic              line_p_o,
  output logic              line_n_o,
  output logic              lpbk_o
);

  logic [WORD_W-1:0] in_word;
  logic              in_vld;
  logic              sh_bit;
  logic              sh_act;

  ser10_in_reg #(.W(WORD_W)) u_in_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (word_stb_i),
    .word_i (word_i),
    .word_o (in_word),
    .vld_o  (in_vld)
  );

  ser10_shifter #(.W(WORD_W)) u_shifter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (word_stb_i),
    .word_i (in_word),
    .vld_i  (in_vld),
    .bit_o  (sh_bit),
    .act_o  (sh_act)
  );

  ser10_out_stage u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_i    (sh_bit),
    .act_i    (sh_act),
    .lpbk_i   (lpbk_i),
    .line_p_o (line_p_o),
    .line_n_o (line_n_o),
    .lpbk_o   (lpbk_o)
  );

endmodule

// File: rtl/ser10_tx_chk.sv
module ser10_tx_chk #(
  parameter int unsigned W = 10
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         word_stb_i,
  input logic         lpbk_i,
  input logic         line_p_o,
  input logic         line_n_o,
  input logic         lpbk_o,
  input logic [W-1:0] in_word_i,
  input logic         in_vld_i,
  input logic         sh_act_i
);

  a_r9_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_n_o == !line_p_o);

  a_r7_line_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lpbk_i |=> (line_p_o && !line_n_o));

  a_r8_lb_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lpbk_i |=> !lpbk_o);

  a_r6_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sh_act_i && !word_stb_i && !lpbk_i) |=> !line_p_o);

  a_r4_first_bit_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_stb_i && in_vld_i) ##1 !lpbk_i |=> line_p_o == $past(in_word_i[0], 2));

  a_r7_first_bit_lb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_stb_i && in_vld_i) ##1 lpbk_i |=> lpbk_o == $past(in_word_i[0], 2));

endmodule

bind ser10_tx ser10_tx_chk #(.W(WORD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .word_stb_i (word_stb_i),
  .lpbk_i     (lpbk_i),
  .line_p_o   (line_p_o),
  .line_n_o   (line_n_o),
  .lpbk_o     (lpbk_o),
  .in_word_i  (in_word),
  .in_vld_i   (in_vld),
  .sh_act_i   (sh_act)
);

// File: tb/ser10_tx_tb.sv
`timescale 1ns/1ps
module ser10_tx_tb;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         stb = 1'b0;
  logic         lpbk = 1'b0;
  logic [W-1:0] word = '0;
  logic         line_p, line_n, lb;

  int    checks = 0;
  int    errors = 0;
  bit    running = 1'b1;
  string req = "R1";

  // behavioural reference
  logic [W-1:0] m_held, m_cur;
  bit           m_have = 1'b0;
  int           m_pos = -1;
  logic         m_b;
  logic         e_p = 1'b0, e_n = 1'b1, e_lb = 1'b0;

  always #5 clk = ~clk;

  ser10_tx #(.WORD_W(W)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .word_stb_i (stb),
    .word_i     (word),
    .lpbk_i     (lpbk),
    .line_p_o   (line_p),
    .line_n_o   (line_n),
    .lpbk_o     (lb)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_have = 1'b0;
      m_pos  = -1;
      e_p = 1'b0; e_n = 1'b1; e_lb = 1'b0;
    end else begin
      m_b  = (m_pos >= 0) ? m_cur[m_pos] : 1'b0;
      e_p  = lpbk ? 1'b1 : m_b;
      e_n  = ~e_p;
      e_lb = lpbk ? m_b : 1'b0;
      if (stb) begin
        if (m_have) begin m_cur = m_held; m_pos = 0; end
        else m_pos = -1;
        m_held = word;
        m_have = 1'b1;
      end else if (m_pos >= 0) begin
        m_pos = (m_pos == W-1) ? -1 : m_pos + 1;
      end
    end
  end

  task automatic chk(string r, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", r, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (running) begin
      if (!rst_n) begin
        chk("R1", "line_p_o in reset", line_p, 1'b0);
        chk("R1", "line_n_o in reset", line_n, 1'b1);
        chk("R1", "lpbk_o in reset", lb, 1'b0);
      end else begin
        chk(req, "line_p_o", line_p, e_p);
        chk(req, "lpbk_o", lb, e_lb);
        chk("R9", "line_n_o", line_n, e_n);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      stb  = 1'b0;
      word = W'($urandom);
    end
  endtask

  task automatic send(logic [W-1:0] w, int gap);
    @(negedge clk);
    stb  = 1'b1;
    word = w;
    idle(gap - 1);
  endtask

  task automatic finish_run();
    running = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    req = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(6);
    // first strobe after reset: nothing held, line stays low
    req = "R3";
    send(10'h2A5, 10);
    // bit ordering with edge-sensitive patterns
    req = "R4";
    send(10'h001, 10);
    send(10'h200, 10);
    send(10'h0FA, 10);
    // back to back stream
    req = "R5";
    send(10'h305, 10);
    send(10'h3FF, 10);
    send(10'h000, 10);
    send(10'h155, 10);
    send(10'h2AA, 10);
    // word_i wiggles between strobes
    req = "R2";
    send(10'h17C, 10);
    send(10'h283, 10);
    // irregular gaps: line must idle low
    req = "R6";
    send(10'h11E, 27);
    send(10'h3C3, 10);
    send(10'h0F0, 14);
    send(10'h3FF, 23);
    idle(10);
    // loopback on, then dropped mid-word
    req = "R7";
    lpbk = 1'b1;
    send(10'h1B6, 10);
    send(10'h3FF, 10);
    send(10'h249, 10);
    send(10'h0C7, 5);
    lpbk = 1'b0;
    req = "R8";
    idle(5);
    send(10'h3A1, 10);
    send(10'h15E, 10);
    lpbk = 1'b1;
    req = "R7";
    idle(3);
    lpbk = 1'b0;
    req = "R8";
    send(10'h2DB, 10);
    send(10'h06D, 10);
    idle(12);
    // reset in mid stream, held word must be dropped
    req = "R1";
    send(10'h3E1, 10);
    send(10'h1F0, 4);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(15);
    req = "R3";
    send(10'h2C9, 10);
    send(10'h136, 10);
    idle(25);
    finish_run();
  end

endmodule